// File: doc/BRIEF.md
# I2C Master Bit-Level Waveform Generator

This block produces the clock and data line waveforms of an I2C bus master, one bus symbol at a time. A byte-level controller above it hands over single commands (begin a transfer, begin a repeated transfer, send one bit, receive one bit, end the transfer). The block turns each command into a timed sequence of line levels and answers with a one-cycle completion pulse that carries the received bit for a receive command.

All timing is counted in system clock cycles and scales with a programmable period value `tpr`. With u = tpr + 1, the clock low phase lasts 12u cycles and is split into two halves of 6u. The old data level is held during the first half. The new level is applied at the midpoint, which leaves 6u cycles of setup before the clock is released. The clock high phase lasts 8u cycles. The start, repeated-start and stop conditions use phase lengths of 12u or 8u. A tpr of 2 gives a 36-cycle low phase and a 24-cycle high phase.

The block never drives a line high. Each line has a "pull low" output. A high level comes from releasing the line to the external pull-up. Both lines are read back through synchronizers, and the high phase count starts only once the released clock line is seen high.

Top module: `i2c_bit_engine`

## Requirements
- R1: While `rst_n` is low, both pull-low outputs are 0, `busy` is 0 and `done` is 0. A reset in the middle of a command releases both lines at once and returns the block to idle.
- R2: Command code 0 (begin transfer), accepted with both lines released: `sda_low` is 1 and `scl_low` is 0 for 12u cycles after the accepting edge. Then `scl_low` becomes 1 in the same cycle that `done` pulses.
- R3: Code 2 (send bit): `scl_low` stays 1 and `sda_low` keeps its previous value for 6u cycles after the accepting edge. Then `sda_low` becomes the inverse of `cmd_bit`, and 6u cycles later `scl_low` drops to 0.
- R4: After the clock line is released, the high phase is counted only on cycles in which the synchronized `scl_in` is high. It lasts 8u counted cycles, so a slow rise of the line lengthens the bit by the rise delay.
- R5: Code 3 (receive bit): `sda_low` is 0 from the midpoint of the low phase on. `sda_in` is sampled at the middle of the high phase, and the sampled level is on `rx_bit` in the cycle `done` pulses.
- R6: Code 1 (repeated begin): `sda_low` goes to 0 at the low-phase midpoint. The clock is then released for 12u counted high cycles, after which `sda_low` becomes 1 with the clock still released for 12u more cycles. Then `scl_low` becomes 1 together with `done`.
- R7: Code 4 (end transfer): `sda_low` becomes 1 at the low-phase midpoint. The clock is released for 8u counted high cycles. Then `sda_low` drops to 0 together with `done`, leaving both lines released.
- R8: A command is taken only when `cmd_valid` is high while the block is idle and the code is 0 to 4. A command that arrives while busy, and codes 5 to 7, change no output.
- R9: `done` is a one-cycle pulse. `busy` is 1 from the cycle after the accepting edge up to the cycle before `done`, and it is 0 when `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tpr | input | TPR_W | Timer period value; u = tpr + 1 |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code (0 begin, 1 repeated begin, 2 send, 3 receive, 4 end) |
| cmd_bit | input | 1 | Bit to send for code 2 |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_bit | output | 1 | Bit sampled by the last receive command |
| scl_low | output | 1 | Pull clock line low when 1, release when 0 |
| sda_low | output | 1 | Pull data line low when 1, release when 0 |
| scl_in | input | 1 | Clock line level read back |
| sda_in | input | 1 | Data line level read back |

## Verification
The bench slows the rise of the released clock line. A design that counts the high phase from the release rather than from the observed high level would end the bit early and fail the per-cycle comparison. It sends bits that repeat and bits that flip the data level, to expose a design that changes data on the clock's falling edge rather than at the low-phase midpoint. It fires a command into a running sequence and presents undefined codes while idle; a design that accepts either would distort the waveform or raise `busy`. It runs the repeated-begin sequence with different period values and reads both data levels, which catches a wrong phase order, a wrong scaling of the phases or a stale sampled bit.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_RESTART = 3'd1,
    OP_WRITE   = 3'd2,
    OP_READ    = 3'd3,
    OP_STOP    = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_SETUP,
    ST_HIGH,
    ST_SHOLD
  } st_e;
endpackage

// File: rtl/i2cb_sync.sv
module i2cb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr[0] <= 1'b1;
        else        sr[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr[i] <= 1'b1;
        else        sr[i] <= sr[i-1];
      end
    end
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/i2cb_period.sv
module i2cb_period #(
  parameter int TPR_W = 8,
  parameter int CNT_W = TPR_W + 5
) (
  input  logic [TPR_W-1:0] tpr,
  output logic [CNT_W-1:0] half_low,
  output logic [CNT_W-1:0] full_low,
  output logic [CNT_W-1:0] full_high
);
  logic [CNT_W-1:0] unit;

  always_comb begin
    unit      = CNT_W'(tpr) + CNT_W'(1);
    half_low  = (unit << 2) + (unit << 1);
    full_low  = half_low << 1;
    full_high = unit << 3;
  end
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2cb_pkg::*;
#(
  parameter int TPR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TPR_W-1:0] tpr,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic             cmd_bit,
  output logic             busy,
  output logic             done,
  output logic             rx_bit,
  output logic             scl_low,
  output logic             sda_low,
  input  logic             scl_in,
  input  logic             sda_in
);
  localparam int CNT_W = TPR_W + 5;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] half_low, full_low, full_high, high_len;
  logic             scl_s, sda_s;

  st_e              st_q, st_d;
  op_e              op_q, op_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tgt_q, tgt_d;
  logic             scl_q, scl_d;
  logic             sda_q, sda_d;
  logic             done_q, done_d;
  logic             rx_q, rx_d;
  logic             accept;

  i2cb_period #(.TPR_W(TPR_W), .CNT_W(CNT_W)) u_period (
    .tpr       (tpr),
    .half_low  (half_low),
    .full_low  (full_low),
    .full_high (full_high)
  );

  i2cb_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk (clk), .rst_n (rst_n), .d (scl_in), .q (scl_s)
  );

  i2cb_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk (clk), .rst_n (rst_n), .d (sda_in), .q (sda_s)
  );

  assign accept   = cmd_valid && (st_q == ST_IDLE) && (cmd_op <= 3'd4);
  assign high_len = (op_q == OP_RESTART) ? full_low : full_high;

  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    cnt_d  = cnt_q;
    tgt_d  = tgt_q;
    scl_d  = scl_q;
    sda_d  = sda_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          cnt_d = '0;
          op_d  = op_e'(cmd_op);
          st_d  = ST_HOLD;
          case (cmd_op)
            3'd0: begin sda_d = 1'b1; st_d = ST_SHOLD; end
            3'd2: tgt_d = ~cmd_bit;
            3'd4: tgt_d = 1'b1;
            default: tgt_d = 1'b0;
          endcase
        end
      end
      ST_HOLD: begin
        cnt_d = cnt_q + ONE;
        if (cnt_q == half_low - ONE) begin
          cnt_d = '0;
          sda_d = tgt_q;
          st_d  = ST_SETUP;
        end
      end
      ST_SETUP: begin
        cnt_d = cnt_q + ONE;
        if (cnt_q == half_low - ONE) begin
          cnt_d = '0;
          scl_d = 1'b0;
          st_d  = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (scl_s) begin
          cnt_d = cnt_q + ONE;
          if (op_q == OP_READ && cnt_q == (full_high >> 1)) rx_d = sda_s;
          if (cnt_q == high_len - ONE) begin
            cnt_d = '0;
            case (op_q)
              OP_RESTART: begin sda_d = 1'b1; st_d = ST_SHOLD; end
              OP_STOP:    begin sda_d = 1'b0; st_d = ST_IDLE; done_d = 1'b1; end
              default:    begin scl_d = 1'b1; st_d = ST_IDLE; done_d = 1'b1; end
            endcase
          end
        end
      end
      ST_SHOLD: begin
        cnt_d = cnt_q + ONE;
        if (cnt_q == full_low - ONE) begin
          cnt_d  = '0;
          scl_d  = 1'b1;
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_START;
      cnt_q  <= '0;
      tgt_q  <= 1'b0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
      done_q <= 1'b0;
      rx_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      cnt_q  <= cnt_d;
      tgt_q  <= tgt_d;
      scl_q  <= scl_d;
      sda_q  <= sda_d;
      done_q <= done_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
  assign rx_bit  = rx_q;
  assign scl_low = scl_q;
  assign sda_low = sda_q;
endmodule

// File: rtl/i2cb_chk.sv
module i2cb_chk #(
  parameter int TPR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TPR_W-1:0] tpr,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic             busy,
  input logic             done,
  input logic             scl_low,
  input logic             sda_low
);
  logic        sda_prev;
  logic [31:0] sda_age;
  logic [31:0] setup_min;

  assign setup_min = (32'(tpr) + 32'd1) * 32'd6 - 32'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_prev <= 1'b0;
      sda_age  <= '0;
    end else begin
      sda_prev <= sda_low;
      if (sda_low != sda_prev)  sda_age <= '0;
      else if (sda_age != '1)   sda_age <= sda_age + 32'd1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!busy && cmd_valid && cmd_op <= 3'd4) |=> busy); // R8
  AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (!busy && cmd_valid && cmd_op > 3'd4) |=> !busy); // R8
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $rose(scl_low) |=> $stable(sda_low)); // R3
  AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n) $fell(scl_low) |-> (sda_age >= setup_min)); // R3
endmodule

bind i2c_bit_engine i2cb_chk #(.TPR_W(TPR_W)) u_i2cb_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tpr       (tpr),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .busy      (busy),
  .done      (done),
  .scl_low   (scl_low),
  .sda_low   (sda_low)
);

// File: tb/test_i2c_bit_engine.sv
module test_i2c_bit_engine;
  localparam int TPR_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [TPR_W-1:0] tpr = 8'd2;
  logic             cmd_valid = 1'b0;
  logic [2:0]       cmd_op = 3'd0;
  logic             cmd_bit = 1'b0;
  logic             busy, done, rx_bit, scl_low, sda_low;
  logic             scl_in, sda_in;
  logic             slave_low = 1'b0;
  int               rise_dly = 0;
  int               rel_cnt = 0;
  int               nchk = 0;
  int               nerr = 0;
  int               e_sda = 0;

  always #2 clk = ~clk;

  // open-drain line model with an adjustable rise delay on the clock line
  always @(negedge clk) begin
    if (scl_low) rel_cnt <= 0;
    else         rel_cnt <= rel_cnt + 1;
  end
  assign scl_in = !scl_low && (rel_cnt >= rise_dly);
  assign sda_in = !sda_low && !slave_low;

  i2c_bit_engine #(.TPR_W(TPR_W), .SYNC_STAGES(2)) i_i2c_bit_engine (
    .clk (clk), .rst_n (rst_n), .tpr (tpr),
    .cmd_valid (cmd_valid), .cmd_op (cmd_op), .cmd_bit (cmd_bit),
    .busy (busy), .done (done), .rx_bit (rx_bit),
    .scl_low (scl_low), .sda_low (sda_low),
    .scl_in (scl_in), .sda_in (sda_in)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s at %0t: actual=%0d expected=%0d", tag, what, $time, act, exp);
    end
  endtask

  task automatic check_idle(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag, "idle sda_low", int'(sda_low), e_sda);
      check(tag, "idle busy", int'(busy), 0);
      check(tag, "idle done", int'(done), 0);
    end
  endtask

  // op: 0 begin, 1 repeated begin, 2 send, 3 receive, 4 end
  task automatic run_cmd(input int op, input bit b, input string tag,
                         input int inj_k, input int inj_op);
    int u, lh, hh, ll, a, e1, e, t, p, es, ed;
    u  = int'(tpr) + 1;
    lh = 6 * u;
    hh = 8 * u;
    ll = 12 * u;
    a  = 2 * lh + ((rise_dly < 1) ? 1 : rise_dly);
    e1 = a + 1 + ((op == 1) ? ll : hh);
    e  = (op == 0) ? ll : (op == 1) ? e1 + ll : e1;
    t  = (op == 2) ? int'(!b) : (op == 4) ? 1 : 0;
    p  = e_sda;
    cmd_valid = 1'b1;
    cmd_op    = 3'(op);
    cmd_bit   = b;
    for (int k = 0; k <= e; k++) begin
      @(negedge clk);
      if (k == 0) cmd_valid = 1'b0;
      if (k == inj_k) begin cmd_valid = 1'b1; cmd_op = 3'(inj_op); cmd_bit = ~b; end
      if (k == inj_k + 1) cmd_valid = 1'b0;
      if (op == 0) begin
        es = (k == e) ? 1 : 0; ed = 1;
      end else if (k < lh) begin
        es = 1; ed = p;
      end else if (k < 2 * lh) begin
        es = 1; ed = t;
      end else if (k < e1) begin
        es = 0; ed = t;
      end else if (op == 1) begin
        es = (k == e) ? 1 : 0; ed = 1;
      end else if (op == 4) begin
        es = 0; ed = 0;
      end else begin
        es = 1; ed = t;
      end
      check(tag, "scl_low", int'(scl_low), es);
      check(tag, "sda_low", int'(sda_low), ed);
      check("R9", "busy", int'(busy), (k < e) ? 1 : 0);
      check("R9", "done", int'(done), (k == e) ? 1 : 0);
      if (op == 3 && k == e) check("R5", "rx_bit", int'(rx_bit), int'(!slave_low));
      if (k == e) e_sda = ed;
    end
  endtask

  initial begin
    #(200000 * 4);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "reset scl_low", int'(scl_low), 0);
    check("R1", "reset sda_low", int'(sda_low), 0);
    check("R1", "reset busy", int'(busy), 0);
    check("R1", "reset done", int'(done), 0);
    rst_n = 1'b1;
    check_idle("R1", 3);

    // tpr = 2: 36/24 cycle phases
    run_cmd(0, 1'b0, "R2", -5, 0);
    run_cmd(2, 1'b1, "R3", -5, 0);
    run_cmd(2, 1'b1, "R3", -5, 0);
    run_cmd(2, 1'b0, "R3", -5, 0);
    slave_low = 1'b1;
    run_cmd(3, 1'b0, "R5", -5, 0);
    slave_low = 1'b0;
    run_cmd(3, 1'b0, "R5", -5, 0);
    run_cmd(1, 1'b0, "R6", -5, 0);
    rise_dly = 5;
    run_cmd(2, 1'b0, "R4", -5, 0);
    slave_low = 1'b1;
    run_cmd(3, 1'b0, "R4", -5, 0);
    slave_low = 1'b0;
    run_cmd(4, 1'b0, "R7", -5, 0);
    check_idle("R7", 4);

    // tpr = 0: short phases, command fired while busy (R8)
    tpr = 8'd0;
    rise_dly = 0;
    run_cmd(0, 1'b0, "R2", -5, 0);
    run_cmd(2, 1'b1, "R8", 3, 4);
    run_cmd(2, 1'b0, "R8", 20, 0);
    run_cmd(3, 1'b0, "R5", -5, 0);
    run_cmd(4, 1'b0, "R7", -5, 0);

    // R8: undefined codes while idle
    for (int c = 5; c < 8; c++) begin
      cmd_valid = 1'b1;
      cmd_op    = 3'(c);
      @(negedge clk);
      cmd_valid = 1'b0;
      check("R8", "bad code scl_low", int'(scl_low), 0);
      check("R8", "bad code busy", int'(busy), 0);
      check_idle("R8", 2);
    end

    // tpr = 1 with slow rise through the repeated begin
    tpr = 8'd1;
    rise_dly = 3;
    run_cmd(0, 1'b0, "R2", -5, 0);
    run_cmd(2, 1'b0, "R3", -5, 0);
    run_cmd(1, 1'b0, "R6", -5, 0);
    run_cmd(4, 1'b0, "R7", -5, 0);

    // R1: reset in the middle of a send
    rise_dly = 0;
    run_cmd(0, 1'b0, "R2", -5, 0);
    cmd_valid = 1'b1;
    cmd_op    = 3'd2;
    cmd_bit   = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (15) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "mid reset scl_low", int'(scl_low), 0);
    check("R1", "mid reset sda_low", int'(sda_low), 0);
    check("R1", "mid reset busy", int'(busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    e_sda = 0;
    check_idle("R1", 3);
    run_cmd(0, 1'b0, "R2", -5, 0);
    run_cmd(4, 1'b0, "R7", -5, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule